// File: doc/BRIEF.md
# Escalating Watchdog Timer

This block supervises software liveness with a countdown that runs on its own dedicated watchdog clock, independent of the system clock. Out of reset it is already armed and counts down from the all-ones value. Software keeps it quiet by sending a refresh strobe, which reloads the count from a programmable reload value. If the count is allowed to reach zero, the block does not reset the chip at once. It raises an interrupt and starts a second, shorter countdown. Software can still recover by sending an acknowledge strobe during that window. If no acknowledge arrives, the block raises a reset request for a fixed four watchdog clocks and then starts over from the all-ones count.

The refresh and acknowledge strobes come from the system clock domain. Each one passes through its own toggle synchronizer into the watchdog domain. A strobe is a single system-clock-cycle pulse, and two strobes of the same kind must be at least two watchdog clocks apart. A board-level strap input turns the internal watchdog on. While the strap is low the block stays idle. The two reload values must be held steady while the block counts. The block has no streaming data path: every pin is a plain control or status level or strobe, with no valid/ready handshake and no back-pressure. The interrupt and reset-request outputs are registered in the watchdog clock domain.

Top module: `wdog_escalate`

## Requirements
- R1: While reset is applied, `wd_irq` and `wd_reset_req` are low. With the strap high, the first `wd_irq` rises exactly 2^CNT_W watchdog clocks after reset is released, counting down from the all-ones value.
- R2: A refresh strobe takes effect on the third watchdog clock edge after the strobe; two edges are spent in the synchronizer. While counting, it loads `main_reload`, and `wd_irq` then rises `main_reload`+1 edges later. A reload of 0 gives an interrupt on the next edge.
- R3: Refresh strobes repeated at intervals shorter than the reload period keep `wd_irq` and `wd_reset_req` low indefinitely.
- R4: When the count is zero and no refresh is pending, `wd_irq` rises and a second countdown loads `timeout_reload`. Without an acknowledge, `wd_reset_req` rises `timeout_reload`+1 watchdog edges after `wd_irq` rose.
- R5: An acknowledge strobe applied while `wd_irq` is high clears `wd_irq`, cancels the pending reset and reloads the main count from `main_reload`. Its synchronizer latency is the same as in R2.
- R6: `wd_reset_req` stays high for exactly 4 watchdog clocks, and `wd_irq` is low meanwhile. The block then counts from all-ones again, so `wd_irq` rises 2^CNT_W edges after `wd_reset_req` falls.
- R7: While the synchronized strap is low, both outputs are low and the count is held at all-ones. Lowering the strap during the interrupt window clears `wd_irq` on the third edge. Raising the strap makes `wd_irq` rise 2^CNT_W+3 edges later.
- R8: A refresh during the interrupt window does not change the reset timing. An acknowledge while counting does not change the time to the interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System clock, used for the strobe inputs |
| sys_rst_n | input | 1 | Asynchronous active-low reset, system domain |
| refresh_req | input | 1 | One-cycle refresh strobe, system domain |
| ack_req | input | 1 | One-cycle interrupt acknowledge strobe, system domain |
| wd_clk | input | 1 | Dedicated watchdog clock |
| wd_rst_n | input | 1 | Asynchronous active-low reset, watchdog domain |
| wd_strap_en | input | 1 | Board strap; high enables the internal watchdog |
| main_reload | input | CNT_W | Value loaded into the main count on refresh or acknowledge |
| timeout_reload | input | TO_W | Value loaded into the reset-timeout countdown on expiry |
| wd_irq | output | 1 | Interrupt, high during the reset-timeout window |
| wd_reset_req | output | 1 | Reset request, high for 4 watchdog clocks |

## Verification
The escalation path is tried with a table of reload pairs, and each pair ends either with an acknowledge or with a missed one. Exact edge counts from the strobe to the interrupt tell a correct load of `main_reload` apart from an off-by-one in the countdown or a wrong synchronizer depth. The counts from the interrupt to the reset request, and the reset pulse width, separate the second countdown from the fixed hold. Directed patterns cover the cases where a strobe has no effect: a refresh during the interrupt window, an acknowledge while counting, and periodic refreshes. A final pattern toggles the strap, which tells the idle hold apart from a restart at all-ones.

// File: rtl/wdog_esc_pkg.sv
package wdog_esc_pkg;

  // Phases of the watchdog, in the watchdog clock domain.
  typedef enum logic [1:0] {
    WS_IDLE  = 2'd0,  // strap low, held at all-ones
    WS_RUN   = 2'd1,  // main countdown
    WS_GRACE = 2'd2,  // interrupt raised, reset-timeout countdown
    WS_HOLD  = 2'd3   // reset request asserted
  } wd_state_e;

  localparam int HOLD_CYCLES = 4;
  localparam int HOLD_W      = $clog2(HOLD_CYCLES);

endpackage

// File: rtl/wdog_level_sync.sv
module wdog_level_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_out
);

  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= {STAGES{RESET_VAL}};
    else        chain <= {chain[STAGES-2:0], async_in};
  end

  assign sync_out = chain[STAGES-1];

endmodule

// File: rtl/wdog_toggle_sync.sv
module wdog_toggle_sync #(
  parameter int STAGES = 2
) (
  input  logic src_clk,
  input  logic src_rst_n,
  input  logic src_pulse,
  input  logic dst_clk,
  input  logic dst_rst_n,
  output logic dst_pulse
);

  logic          src_tog;
  logic [STAGES:0] chain;

  // Each source pulse flips one level; the level crosses, not the pulse.
  always_ff @(posedge src_clk or negedge src_rst_n) begin
    if (!src_rst_n)     src_tog <= 1'b0;
    else if (src_pulse) src_tog <= ~src_tog;
  end

  always_ff @(posedge dst_clk or negedge dst_rst_n) begin
    if (!dst_rst_n) chain <= '0;
    else            chain <= {chain[STAGES-1:0], src_tog};
  end

  // Edge of the synchronized level gives one destination pulse.
  assign dst_pulse = chain[STAGES] ^ chain[STAGES-1];

endmodule

// File: rtl/wdog_esc_core.sv
module wdog_esc_core
  import wdog_esc_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int TO_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wd_en,
  input  logic             refresh,
  input  logic             ack,
  input  logic [CNT_W-1:0] main_reload,
  input  logic [TO_W-1:0]  timeout_reload,
  output logic             irq,
  output logic             reset_req
);

  localparam logic [CNT_W-1:0]  CNT_MAX   = '1;
  localparam logic [HOLD_W-1:0] HOLD_LAST = HOLD_W'(HOLD_CYCLES - 1);

  wd_state_e         state;
  logic [CNT_W-1:0]  main_cnt;
  logic [TO_W-1:0]   to_cnt;
  logic [HOLD_W-1:0] hold_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= WS_RUN;
      main_cnt <= CNT_MAX;
      to_cnt   <= '0;
      hold_cnt <= '0;
    end else if (!wd_en) begin
      state    <= WS_IDLE;
      main_cnt <= CNT_MAX;
      to_cnt   <= '0;
      hold_cnt <= '0;
    end else begin
      unique case (state)
        WS_IDLE: begin
          state    <= WS_RUN;
          main_cnt <= CNT_MAX;
        end
        WS_RUN: begin
          if (refresh) begin
            main_cnt <= main_reload;
          end else if (main_cnt == '0) begin
            state  <= WS_GRACE;
            to_cnt <= timeout_reload;
          end else begin
            main_cnt <= main_cnt - CNT_W'(1);
          end
        end
        WS_GRACE: begin
          if (ack) begin
            state    <= WS_RUN;
            main_cnt <= main_reload;
          end else if (to_cnt == '0) begin
            state    <= WS_HOLD;
            hold_cnt <= HOLD_LAST;
          end else begin
            to_cnt <= to_cnt - TO_W'(1);
          end
        end
        WS_HOLD: begin
          if (hold_cnt == '0) begin
            state    <= WS_RUN;
            main_cnt <= CNT_MAX;
          end else begin
            hold_cnt <= hold_cnt - HOLD_W'(1);
          end
        end
        default: state <= WS_IDLE;
      endcase
    end
  end

  assign irq       = (state == WS_GRACE);
  assign reset_req = (state == WS_HOLD);

  // R7
  strap_off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wd_en |=> (!irq && !reset_req));

  // R6
  irq_rst_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq && reset_req));

  // R6
  hold_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(reset_req) && $past(wd_en)) |-> $past(reset_req, 4));

  // R4
  irq_from_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(main_cnt) == '0));

  // R4
  rst_after_timeout_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reset_req) |-> ($past(irq) && $past(to_cnt) == '0));

  // R5
  ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && ack && wd_en) |=> (!irq && !reset_req && main_cnt == $past(main_reload)));

  // R2
  refresh_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == WS_RUN && refresh && wd_en) |=> (main_cnt == $past(main_reload)));

endmodule

// File: rtl/wdog_escalate.sv
module wdog_escalate #(
  parameter int CNT_W       = 16,
  parameter int TO_W        = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             sys_clk,
  input  logic             sys_rst_n,
  input  logic             refresh_req,
  input  logic             ack_req,
  input  logic             wd_clk,
  input  logic             wd_rst_n,
  input  logic             wd_strap_en,
  input  logic [CNT_W-1:0] main_reload,
  input  logic [TO_W-1:0]  timeout_reload,
  output logic             wd_irq,
  output logic             wd_reset_req
);

  localparam int NUM_STROBES = 2;  // [0] refresh, [1] acknowledge

  logic [NUM_STROBES-1:0] sys_strobe;
  logic [NUM_STROBES-1:0] wd_strobe;
  logic                   strap_sync;

  assign sys_strobe = {ack_req, refresh_req};

  for (genvar g = 0; g < NUM_STROBES; g++) begin : g_strobe
    wdog_toggle_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .src_clk   (sys_clk),
      .src_rst_n (sys_rst_n),
      .src_pulse (sys_strobe[g]),
      .dst_clk   (wd_clk),
      .dst_rst_n (wd_rst_n),
      .dst_pulse (wd_strobe[g])
    );
  end

  // Reset value 1: the watchdog is armed straight out of reset.
  wdog_level_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_strap_sync (
    .clk      (wd_clk),
    .rst_n    (wd_rst_n),
    .async_in (wd_strap_en),
    .sync_out (strap_sync)
  );

  wdog_esc_core #(.CNT_W(CNT_W), .TO_W(TO_W)) u_core (
    .clk            (wd_clk),
    .rst_n          (wd_rst_n),
    .wd_en          (strap_sync),
    .refresh        (wd_strobe[0]),
    .ack            (wd_strobe[1]),
    .main_reload    (main_reload),
    .timeout_reload (timeout_reload),
    .irq            (wd_irq),
    .reset_req      (wd_reset_req)
  );

endmodule

// File: tb/wdog_escalate_tb.sv
module wdog_escalate_tb;

  localparam int CNT_W  = 6;
  localparam int TO_W   = 4;
  localparam int PERIOD = 64;   // 2^CNT_W
  localparam int NVEC   = 6;

  // {main_reload[10:5], timeout_reload[4:1], acknowledge[0]}
  localparam logic [10:0] VEC [NVEC] = '{
    {6'd10, 4'd5,  1'b0},
    {6'd20, 4'd7,  1'b1},
    {6'd3,  4'd3,  1'b1},
    {6'd0,  4'd4,  1'b0},
    {6'd40, 4'd15, 1'b0},
    {6'd17, 4'd9,  1'b1}
  };

  logic             sys_clk = 1'b0;
  logic             wd_clk  = 1'b0;
  logic             rst_n   = 1'b0;
  logic             refresh_req = 1'b0;
  logic             ack_req     = 1'b0;
  logic             strap       = 1'b1;
  logic [CNT_W-1:0] main_reload    = '0;
  logic [TO_W-1:0]  timeout_reload = '0;
  logic             wd_irq;
  logic             wd_reset_req;

  int checks = 0;
  int errors = 0;

  always #10 sys_clk = ~sys_clk;   // 50 MHz
  always #30 wd_clk  = ~wd_clk;

  wdog_escalate #(.CNT_W(CNT_W), .TO_W(TO_W), .SYNC_STAGES(2)) u_dut (
    .sys_clk        (sys_clk),
    .sys_rst_n      (rst_n),
    .refresh_req    (refresh_req),
    .ack_req        (ack_req),
    .wd_clk         (wd_clk),
    .wd_rst_n       (rst_n),
    .wd_strap_en    (strap),
    .main_reload    (main_reload),
    .timeout_reload (timeout_reload),
    .wd_irq         (wd_irq),
    .wd_reset_req   (wd_reset_req)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge wd_clk);
    @(negedge wd_clk);
  endtask

  task automatic pulse_refresh();
    refresh_req = 1'b1;
    @(posedge sys_clk);
    #1 refresh_req = 1'b0;
  endtask

  task automatic pulse_ack();
    ack_req = 1'b1;
    @(posedge sys_clk);
    #1 ack_req = 1'b0;
  endtask

  // Edges until wd_irq is seen high; also notes any reset request seen.
  task automatic edges_to_irq(input int limit, output int n, output bit saw_rst);
    n = 0;
    saw_rst = 1'b0;
    while (n < limit) begin
      tick();
      n++;
      if (wd_reset_req) saw_rst = 1'b1;
      if (wd_irq) break;
    end
  endtask

  task automatic edges_to_rst(input int limit, output int n);
    n = 0;
    while (n < limit) begin
      tick();
      n++;
      if (wd_reset_req) break;
    end
  endtask

  // Called right after wd_reset_req was first seen; counts high samples.
  task automatic hold_width(output int width, output bit irq_seen);
    width = 1;
    irq_seen = wd_irq;
    for (int i = 0; i < 10; i++) begin
      tick();
      if (!wd_reset_req) break;
      width++;
      if (wd_irq) irq_seen = 1'b1;
    end
  endtask

  initial begin
    repeat (150000) @(posedge sys_clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int  n;
    int  w;
    bit  flag;
    bit  any;

    // ---------------- reset and first expiry ----------------
    timeout_reload = 4'd5;
    main_reload    = 6'd10;
    repeat (3) tick();
    check(!wd_irq && !wd_reset_req, "R1 outputs low in reset", {wd_irq, wd_reset_req}, 0);
    rst_n = 1'b1;                                   // released at a negedge
    edges_to_irq(200, n, flag);
    check(n == PERIOD, "R1 first irq from all-ones", n, PERIOD);
    check(!flag, "R1 no reset before irq", flag, 0);
    edges_to_rst(50, n);
    check(n == 6, "R4 reset after timeout", n, 6);
    hold_width(w, flag);
    check(w == 4, "R6 reset width", w, 4);
    check(!flag, "R6 irq low during reset", flag, 0);
    edges_to_irq(200, n, flag);
    check(n == PERIOD, "R6 restart from all-ones", n, PERIOD);

    // refresh inside the interrupt window must not change the reset timing
    pulse_refresh();
    edges_to_rst(50, n);
    check(n == 6, "R8 refresh in window ignored", n, 6);
    hold_width(w, flag);
    check(w == 4, "R6 reset width again", w, 4);

    // ---------------- vector table ----------------
    for (int v = 0; v < NVEC; v++) begin
      logic [5:0] rl;
      logic [3:0] to;
      logic       do_ack;
      {rl, to, do_ack} = VEC[v];
      main_reload    = rl;
      timeout_reload = to;
      pulse_refresh();
      edges_to_irq(200, n, flag);
      check(n == int'(rl) + 4, "R2 refresh to irq", n, int'(rl) + 4);
      if (do_ack) begin
        pulse_ack();
        any = 1'b0;
        n = 0;
        while (n < 20) begin
          tick();
          n++;
          if (wd_reset_req) any = 1'b1;
          if (!wd_irq) break;
        end
        check(n == 3, "R5 ack clears irq", n, 3);
        check(!any, "R5 ack cancels reset", any, 0);
      end else begin
        edges_to_rst(50, n);
        check(n == int'(to) + 1, "R4 irq to reset", n, int'(to) + 1);
        hold_width(w, flag);
        check(w == 4, "R6 reset width in table", w, 4);
      end
    end

    // ---------------- periodic refresh ----------------
    main_reload    = 6'd40;
    timeout_reload = 4'd15;
    any = 1'b0;
    for (int k = 0; k < 15; k++) begin
      pulse_refresh();
      for (int j = 0; j < 20; j++) begin
        tick();
        if (wd_irq || wd_reset_req) any = 1'b1;
      end
    end
    check(!any, "R3 periodic refresh keeps quiet", any, 0);

    // ---------------- ack while counting is ignored ----------------
    main_reload = 6'd20;
    pulse_refresh();
    repeat (5) tick();
    pulse_ack();
    edges_to_irq(200, n, flag);
    check(n + 5 == 24, "R8 ack while counting ignored", n + 5, 24);

    // ---------------- strap low in the interrupt window ----------------
    strap = 1'b0;
    repeat (2) tick();
    check(wd_irq, "R7 irq held until strap syncs", wd_irq, 1);
    tick();
    check(!wd_irq && !wd_reset_req, "R7 strap low clears irq", wd_irq, 0);
    any = 1'b0;
    for (int j = 0; j < 200; j++) begin
      tick();
      if (wd_irq || wd_reset_req) any = 1'b1;
    end
    check(!any, "R7 idle while strap low", any, 0);
    strap = 1'b1;
    edges_to_irq(300, n, flag);
    check(n == PERIOD + 3, "R7 strap high restarts from all-ones", n, PERIOD + 3);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule